// File: doc/BRIEF.md
# Step Attenuator Serial Programming Sequencer

This block is the host-side driver for a digital step attenuator that is programmed over a three-wire serial link: data, clock and latch enable. A client hands it an attenuation level in quarter-dB units and a 3-bit device address through a valid/ready handshake. The block builds a 16-bit frame. The frame carries the attenuation byte first and the address byte second, and each byte goes out least significant bit first. The block then toggles the serial pins and finishes with a latch pulse. Levels above 127 (31.75 dB) are clamped to 127. The top bit of the attenuation byte and the upper five bits of the address byte are always sent as zero.

Every timing interval is a parameter counted in system clock cycles: clock low phase, clock high phase, the gap before the latch, and the latch pulse width. A parameter set is rejected at elaboration when it falls below any of these minimums:

- 30 ns clock high time
- 30 ns clock low time
- 100 ns clock period
- 10 ns from the last rising clock edge to the latch
- 30 ns latch pulse

Data changes only on falling clock edges, so each rising edge sees the whole low phase as setup time and the whole high phase as hold time.

The sequencer is a state machine with six states:

- SQ_IDLE: ready is high. The transition accept (valid while idle) loads the frame and moves to SQ_LOW.
- SQ_LOW: the clock is low and the current bit is on the data line. The transition phase-end goes to SQ_HIGH.
- SQ_HIGH: the clock is high. The transition next-bit shifts the frame and goes back to SQ_LOW. The transition last-bit (after 16 bits) goes to SQ_GAP.
- SQ_GAP: the clock is low and the latch has not yet risen. The transition setup-met goes to SQ_LATCH.
- SQ_LATCH: the latch enable is high. The transition pulse-end goes to SQ_DONE.
- SQ_DONE: the latch enable is low again and done is high for one cycle. The transition return goes to SQ_IDLE.

Top module: `atten_ser_seq`

## Requirements
- R1: The frame has exactly 16 rising edges of `ser_clk`. Bit i of the frame is sampled on rising edge i (i = 0 first). Frame bits 7:0 are the attenuation byte and bits 15:8 are the address byte, so bit 0 is the attenuation LSB and bit 8 is address bit 0.
- R2: The attenuation byte equals `req_level` when `req_level` ≤ 127, and 127 otherwise. Its bit 7 (frame bit 7) is always 0.
- R3: Frame bits 10:8 carry `req_addr[2:0]` and frame bits 15:11 are 0.
- R4: Each serial bit has `ser_clk` low for exactly CLK_LOW_CYC cycles and then high for exactly CLK_HIGH_CYC cycles. `ser_data` changes only while `ser_clk` is low and never in the cycle in which `ser_clk` rises.
- R5: `ser_le` stays low throughout shifting. It rises exactly CLK_HIGH_CYC + LE_SETUP_CYC cycles after the 16th rising edge of `ser_clk`, and `ser_clk` is low while `ser_le` is high.
- R6: `ser_le` stays high for exactly LE_WIDTH_CYC cycles and then returns low.
- R7: `done` is high for exactly one cycle, and it is the cycle in which `ser_le` has just fallen. That cycle is 16·(CLK_LOW_CYC+CLK_HIGH_CYC) + LE_SETUP_CYC + LE_WIDTH_CYC cycles after the accepting edge.
- R8: `req_ready` is low from the cycle after a request is accepted through the `done` cycle, and high in the cycle after it. While it is low, `req_valid` and the request fields have no effect on the frame being sent.
- R9: On reset and whenever the block is idle, `ser_clk`, `ser_le` and `done` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_level | input | 8 | Attenuation in quarter-dB steps; values above 127 are clamped |
| req_addr | input | 3 | Target device address |
| ser_data | output | 1 | Serial data, changes on falling clock edges |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_le | output | 1 | Latch enable pulse after the frame |
| done | output | 1 | One-cycle pulse when the latch pulse ends |

## Verification
Every output settles in the first cycle after the accepting clock edge, because the pins are registered from the next state. The bench therefore numbers its samples from that edge and takes each sample at the falling system clock edge.

From the parameters, the bench works out the cycle in which each event is due:

| Event | Due cycle |
|---|---|
| Serial rising edge i | i·(L+H)+L |
| Serial falling edge i | i·(L+H)+L+H |
| Latch rise | 16·(L+H)+S |
| Latch fall | 16·(L+H)+S+W |
| `done` | 16·(L+H)+S+W |
| `req_ready` returns high | one cycle after `done` |

Here L, H, S and W are CLK_LOW_CYC, CLK_HIGH_CYC, LE_SETUP_CYC and LE_WIDTH_CYC. The bench compares the observed cycle of each event with these numbers.

All 256 request levels are swept, with addresses rotating through all eight values. In some frames `req_valid` is held high with different data during the busy period.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;

    localparam int WORD_BITS  = 8;
    localparam int FRAME_BITS = 2 * WORD_BITS;
    localparam int ADDR_BITS  = 3;
    localparam int LEVEL_MAX  = 127;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LOW,
        SQ_HIGH,
        SQ_GAP,
        SQ_LATCH,
        SQ_DONE
    } seq_state_t;

endpackage

// File: rtl/atten_frame_build.sv
module atten_frame_build
    import atten_ser_pkg::*;
(
    input  logic [WORD_BITS-1:0]  level,
    input  logic [ADDR_BITS-1:0]  addr,
    output logic [FRAME_BITS-1:0] frame
);
    logic [WORD_BITS-1:0] level_sat;
    logic [WORD_BITS-1:0] addr_byte;

    always_comb begin
        if (level > WORD_BITS'(LEVEL_MAX)) begin
            level_sat = WORD_BITS'(LEVEL_MAX);
        end else begin
            level_sat = level;
        end
        // top bit of the attenuation byte is always transmitted as zero
        level_sat[WORD_BITS-1] = 1'b0;
        addr_byte = '0;
        addr_byte[ADDR_BITS-1:0] = addr;
    end

    // attenuation byte occupies the low half so it leaves the shifter first
    assign frame = {addr_byte, level_sat};

endmodule

// File: rtl/seq_interval_timer.sv
module seq_interval_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // a phase loaded with N lasts exactly N cycles
    assign expire = (cnt == CNT_W'(1));

endmodule

// File: rtl/atten_ser_seq.sv
module atten_ser_seq
    import atten_ser_pkg::*;
#(
    parameter int SYS_CLK_NS   = 10,
    parameter int CLK_LOW_CYC  = 5,
    parameter int CLK_HIGH_CYC = 5,
    parameter int LE_SETUP_CYC = 1,
    parameter int LE_WIDTH_CYC = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [WORD_BITS-1:0] req_level,
    input  logic [ADDR_BITS-1:0] req_addr,
    output logic                 ser_data,
    output logic                 ser_clk,
    output logic                 ser_le,
    output logic                 done
);
    localparam int MAX_AB  = (CLK_LOW_CYC > CLK_HIGH_CYC) ? CLK_LOW_CYC : CLK_HIGH_CYC;
    localparam int MAX_CD  = (LE_SETUP_CYC > LE_WIDTH_CYC) ? LE_SETUP_CYC : LE_WIDTH_CYC;
    localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);
    localparam int BIT_W   = $clog2(FRAME_BITS);

    localparam bit CFG_OK =
        (CLK_LOW_CYC >= 1) && (CLK_HIGH_CYC >= 1) &&
        (LE_SETUP_CYC >= 1) && (LE_WIDTH_CYC >= 1) &&
        (CLK_LOW_CYC * SYS_CLK_NS >= 30) &&
        (CLK_HIGH_CYC * SYS_CLK_NS >= 30) &&
        ((CLK_LOW_CYC + CLK_HIGH_CYC) * SYS_CLK_NS >= 100) &&
        (LE_SETUP_CYC * SYS_CLK_NS >= 10) &&
        (LE_WIDTH_CYC * SYS_CLK_NS >= 30);

    generate
        if (!CFG_OK) begin : g_cfg_reject
            $error("atten_ser_seq: timing parameters below serial interface minimums");
        end
    endgenerate

    seq_state_t state, state_nxt;

    logic [FRAME_BITS-1:0] frame_new;
    logic [FRAME_BITS-1:0] shreg;
    logic [BIT_W-1:0]      bit_idx;
    logic                  tmr_load;
    logic [TMR_W-1:0]      tmr_val;
    logic                  tmr_exp;
    logic                  last_bit;

    atten_frame_build u_frame (
        .level (req_level),
        .addr  (req_addr),
        .frame (frame_new)
    );

    seq_interval_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_exp)
    );

    assign last_bit  = (bit_idx == BIT_W'(FRAME_BITS - 1));
    assign req_ready = (state == SQ_IDLE);
    assign ser_data  = shreg[0];

    always_comb begin
        state_nxt = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state)
            SQ_IDLE: if (req_valid) begin
                state_nxt = SQ_LOW;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(CLK_LOW_CYC);
            end
            SQ_LOW: if (tmr_exp) begin
                state_nxt = SQ_HIGH;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(CLK_HIGH_CYC);
            end
            SQ_HIGH: if (tmr_exp) begin
                tmr_load = 1'b1;
                if (last_bit) begin
                    state_nxt = SQ_GAP;
                    tmr_val   = TMR_W'(LE_SETUP_CYC);
                end else begin
                    state_nxt = SQ_LOW;
                    tmr_val   = TMR_W'(CLK_LOW_CYC);
                end
            end
            SQ_GAP: if (tmr_exp) begin
                state_nxt = SQ_LATCH;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(LE_WIDTH_CYC);
            end
            SQ_LATCH: if (tmr_exp) begin
                state_nxt = SQ_DONE;
            end
            SQ_DONE: state_nxt = SQ_IDLE;
            default: state_nxt = SQ_IDLE;
        endcase
    end

    // state register together with the frame shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            shreg   <= '0;
            bit_idx <= '0;
        end else begin
            state <= state_nxt;
            if (state == SQ_IDLE && req_valid) begin
                shreg   <= frame_new;
                bit_idx <= '0;
            end else if (state == SQ_HIGH && tmr_exp && !last_bit) begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + 1'b1;
            end else if (state == SQ_DONE) begin
                shreg <= '0;
            end
        end
    end

    // pins registered from the next state so they never glitch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_clk <= 1'b0;
            ser_le  <= 1'b0;
            done    <= 1'b0;
        end else begin
            ser_clk <= (state_nxt == SQ_HIGH);
            ser_le  <= (state_nxt == SQ_LATCH);
            done    <= (state_nxt == SQ_DONE);
        end
    end

    AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ser_clk && !ser_le && !done)); // R9
    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8
    AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready && !done)); // R7
    AST_LE_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_le) |-> done); // R7
    AST_LE_CLK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ser_le |-> !ser_clk); // R5
    AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data)); // R4
    AST_DATA_SETUP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_data)); // R4

endmodule

// File: tb/tb_atten_ser_seq.sv
module tb_atten_ser_seq;
    localparam int CLK_NS = 10;
    localparam int L = 5;
    localparam int H = 5;
    localparam int S = 1;
    localparam int W = 3;
    localparam int TOTAL = 16 * (L + H) + S + W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [7:0] req_level = '0;
    logic [2:0] req_addr = '0;
    logic       ser_data, ser_clk, ser_le, done;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_NS / 2) clk = ~clk;

    atten_ser_seq #(
        .SYS_CLK_NS  (CLK_NS),
        .CLK_LOW_CYC (L),
        .CLK_HIGH_CYC(H),
        .LE_SETUP_CYC(S),
        .LE_WIDTH_CYC(W)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_level (req_level),
        .req_addr  (req_addr),
        .ser_data  (ser_data),
        .ser_clk   (ser_clk),
        .ser_le    (ser_le),
        .done      (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic send_frame(input int lvl, input int adr, input bit busy_junk);
        int  rises, falls, le_rise_n, le_fall_n, done_n, done_cnt;
        int  tviol, dviol, ready_viol, le_early;
        int  frame_got, exp_lvl, exp_frame;
        bit  pclk, pdata, ple;
        rises = 0; falls = 0; le_rise_n = -1; le_fall_n = -1; done_n = -1; done_cnt = 0;
        tviol = 0; dviol = 0; ready_viol = 0; le_early = 0; frame_got = 0;
        pclk = 1'b0; pdata = 1'b0; ple = 1'b0;

        @(negedge clk);
        check(req_ready == 1'b1, "R9 ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_level = 8'(lvl);
        req_addr  = 3'(adr);
        @(posedge clk);
        for (int n = 0; n <= TOTAL + 1; n++) begin
            @(negedge clk);
            if (busy_junk && done_n < 0) begin
                // R8: new request fields while busy must not alter the frame
                req_level = 8'(lvl ^ 8'h5A);
                req_addr  = 3'(adr + 3);
            end else begin
                req_valid = 1'b0;
            end
            if (n <= TOTAL && req_ready) ready_viol++;
            if (ser_clk && !pclk) begin
                if (rises < 16) frame_got |= int'(ser_data) << rises;
                if (n != rises * (L + H) + L) tviol++;
                if (ser_data != pdata) dviol++;
                rises++;
            end
            if (!ser_clk && pclk) begin
                if (n != (falls * (L + H)) + L + H) tviol++;
                falls++;
            end
            if (ser_clk && pclk && ser_data != pdata) dviol++;
            if (ser_le && !ple) begin
                le_rise_n = n;
                if (rises < 16 || falls < 16) le_early++;
            end
            if (!ser_le && ple) le_fall_n = n;
            if (ser_le && ser_clk) le_early++;
            if (done) begin
                done_cnt++;
                done_n = n;
                req_valid = 1'b0;
            end
            if (n == TOTAL + 1) begin
                check(req_ready == 1'b1, "R8 ready after done", int'(req_ready), 1);
                check(!ser_clk && !ser_le && !done, "R9 idle pins low",
                      int'({ser_clk, ser_le, done}), 0);
            end
            pclk = ser_clk; pdata = ser_data; ple = ser_le;
        end

        exp_lvl   = (lvl > 127) ? 127 : lvl;
        exp_frame = exp_lvl + (adr << 8);
        check(rises == 16, "R1 rising edge count", rises, 16);
        check((frame_got & 8'h7F) == (exp_lvl & 8'h7F), "R1 attenuation bits", frame_got & 8'h7F, exp_lvl);
        check(((frame_got >> 7) & 1) == 0, "R2 bit7 zero / clamp", (frame_got >> 7) & 1, 0);
        if (lvl > 127) check((frame_got & 8'hFF) == 127, "R2 clamp to 127", frame_got & 8'hFF, 127);
        check((frame_got >> 8) == adr, "R3 address byte", frame_got >> 8, adr);
        check(frame_got == exp_frame, "R1 whole frame", frame_got, exp_frame);
        check(tviol == 0 && falls == 16, "R4 clock phase timing", tviol, 0);
        check(dviol == 0, "R4 data stable at/through high", dviol, 0);
        check(le_rise_n == 15 * (L + H) + L + H + S, "R5 latch rise cycle", le_rise_n, 16 * (L + H) + S);
        check(le_early == 0, "R5 latch low while shifting", le_early, 0);
        check(le_fall_n - le_rise_n == W, "R6 latch width", le_fall_n - le_rise_n, W);
        check(done_cnt == 1 && done_n == TOTAL, "R7 done cycle", done_n, TOTAL);
        check(done_n == le_fall_n, "R7 done with latch fall", done_n, le_fall_n);
        check(ready_viol == 0, "R8 ready low while busy", ready_viol, 0);
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R9 reset ready", int'(req_ready), 1);
        check(!ser_clk && !ser_le && !done, "R9 reset pins low", int'({ser_clk, ser_le, done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!ser_clk && !ser_le && !done && req_ready, "R9 idle after reset",
              int'({ser_clk, ser_le, done}), 0);
        for (int v = 0; v < 256; v++) begin
            send_frame(v, v % 8, (v % 16) == 5);
        end
        send_frame(255, 7, 1'b1);
        send_frame(128, 0, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule